// File: doc/BRIEF.md
# Memory Upset Readback Monitor

This block is a test controller for measuring bit upsets in a word-addressed static memory. On a start request it writes every word of the array with one of a few fixed data patterns. It then runs in monitoring mode for as long as it stays out of reset. A programmable prescaler on the system clock sets how often it reads the whole array back. No writes happen after the fill.

Each word read during a scan is compared with the value the same address held on the previous scan, not with the fill pattern. A private shadow copy of the previous scan supplies that reference, and the copy is refreshed after every comparison. A bit that flips is therefore reported once, in the scan that first sees it.

Every change produces one record on a valid/ready stream. The record carries the word address, the newly read word, the mask of flipped bits, the number of flipped bits, a multi-bit flag and the index of the scan that found it. The memory under test is a behavioural model inside the block. It has a side port that injects faults by inverting chosen bits of a stored word.

Top module: `upset_monitor`

## Requirements
- R1: A `start` pulse while idle fills every word with the pattern picked by `pattern_sel`, one word per cycle in ascending address order. The encodings are: 0 gives the low three eighths of the bits set (0x003F for 16-bit words), 1 gives all zeros, 2 gives all ones, and 3 gives all zeros.
- R2: A fault presented while the fill is writing has no effect on the stored data, so the first scan after the fill reports nothing.
- R3: Scan starts are spaced exactly `scan_period` clock cycles apart, counted from the end of the fill; a period of 0 or 1 acts as 1. `scan_done` is a single-cycle pulse at the end of each full scan, so when nothing stalls, consecutive pulses are exactly `scan_period` cycles apart.
- R4: A word whose read value differs from its value in the previous scan produces exactly one record. The record holds the new data in `rec_data` and the XOR of old and new in `rec_mask`. An unchanged word produces no record, and a bit that flipped is not reported again on later scans.
- R5: Within one scan, records leave in ascending address order.
- R6: `rec_count` equals the number of set bits in `rec_mask`, and `rec_multi` is high exactly when that number is two or more.
- R7: `rec_stamp` is the index of the scan that found the change. The first scan after the fill is index 0, and the index rises by one for each completed scan.
- R8: While `rec_valid` is high and `rec_ready` is low, the record holds stable and scanning pauses, so no record is ever dropped.
- R9: A scan start that falls due while a scan is still in progress is skipped and sets `overrun`. With a scan taking two cycles per word, any period of at most twice the word count sets it. Once set, `overrun` stays high until reset.
- R10: After reset, `rec_valid`, `scan_done` and `overrun` are low.
- R11: A fault that inverts the same bits of a word twice between two scans leaves the word unchanged and produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins fill and monitoring; used only when idle |
| pattern_sel | input | 2 | Fill pattern select |
| scan_period | input | PERIOD_W | Clock cycles between scan starts |
| flip_en | input | 1 | Fault injection strobe |
| flip_addr | input | ADDR_W | Word hit by the fault |
| flip_mask | input | DATA_W | Bits of that word to invert |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_addr | output | ADDR_W | Address of the changed word |
| rec_data | output | DATA_W | Newly read word |
| rec_mask | output | DATA_W | Bits that changed since the previous scan |
| rec_count | output | CNT_W | Number of changed bits |
| rec_multi | output | 1 | Two or more bits changed in the word |
| rec_stamp | output | STAMP_W | Index of the scan that found the change |
| scan_done | output | 1 | One-cycle pulse at the end of each scan |
| overrun | output | 1 | Sticky: a scan start was skipped |

## Verification
The interesting collision is the stalled output slot being drained in the same cycle that the compare stage has a new record ready to load into it. When `rec_ready` rises after a long stall, the pending record is accepted and the next changed word is captured on the same edge. The bench provokes this by holding `rec_ready` low across a scan that contains several upsets, so that a scan tick also lands during the stall. It then judges the result by requiring every record to arrive once, in address order and with the stalled scan's index, and by requiring `overrun` to have been set.

// File: rtl/upset_mon_pkg.sv
`timescale 1ns/1ps
package upset_mon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_READ,
    ST_CMP
  } mon_state_e;

  // Fill word for a given selector; width-generic, truncated by the caller.
  function automatic logic [63:0] fill_word(input logic [1:0] sel, input int unsigned width);
    logic [63:0] w;
    case (sel)
      2'd0:    w = (64'd1 << ((width * 3) / 8)) - 64'd1;
      2'd2:    w = {64{1'b1}};
      default: w = 64'd0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sram_model.sv
`timescale 1ns/1ps
module sram_model #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flt_en,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [DATA_W-1:0] flt_mask
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Functional write has priority; a fault lands only when no write is active.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wr_data;
    end else if (flt_en) begin
      mem[flt_addr] <= mem[flt_addr] ^ flt_mask;
    end
    if (rd_en) begin
      rd_data <= mem[addr];
    end
  end
endmodule

// File: rtl/shadow_ram.sv
`timescale 1ns/1ps
module shadow_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wr_data;
    end
    if (rd_en) begin
      rd_data <= mem[addr];
    end
  end
endmodule

// File: rtl/scan_timer.sv
`timescale 1ns/1ps
module scan_timer #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;
  logic                wrap;

  assign wrap = (period <= PERIOD_W'(1)) || (cnt == period - PERIOD_W'(1));
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PERIOD_W'(1);
    end
  end
endmodule

// File: rtl/upset_monitor.sv
`timescale 1ns/1ps
module upset_monitor
  import upset_mon_pkg::*;
#(
  parameter  int ADDR_W   = 12,
  parameter  int DATA_W   = 16,
  parameter  int PERIOD_W = 32,
  parameter  int STAMP_W  = 16,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          pattern_sel,
  input  logic [PERIOD_W-1:0] scan_period,
  input  logic                flip_en,
  input  logic [ADDR_W-1:0]   flip_addr,
  input  logic [DATA_W-1:0]   flip_mask,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [ADDR_W-1:0]   rec_addr,
  output logic [DATA_W-1:0]   rec_data,
  output logic [DATA_W-1:0]   rec_mask,
  output logic [CNT_W-1:0]    rec_count,
  output logic                rec_multi,
  output logic [STAMP_W-1:0]  rec_stamp,
  output logic                scan_done,
  output logic                overrun
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  mon_state_e          state;
  logic [ADDR_W-1:0]   addr;
  logic [DATA_W-1:0]   pat;
  logic [STAMP_W-1:0]  scan_idx;

  logic [DATA_W-1:0]   cur_word;
  logic [DATA_W-1:0]   old_word;
  logic [DATA_W-1:0]   diff;
  logic [CNT_W-1:0]    ones_n;
  logic                changed;
  logic                slot_free;
  logic                advance;
  logic                load;
  logic                at_top;
  logic                tick;
  logic                timer_run;
  logic                scanning;

  assign at_top    = (addr == TOP_ADDR);
  assign scanning  = (state == ST_READ) || (state == ST_CMP);
  assign timer_run = (state == ST_WAIT) || scanning;

  assign diff      = cur_word ^ old_word;
  assign changed   = |diff;
  assign ones_n    = CNT_W'($countones(diff));
  assign slot_free = !rec_valid || rec_ready;
  assign advance   = (state == ST_CMP) && (!changed || slot_free);
  assign load      = (state == ST_CMP) && changed && slot_free;

  scan_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (timer_run),
    .period (scan_period),
    .tick   (tick)
  );

  sram_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .wr_en    (state == ST_FILL),
    .rd_en    (state == ST_READ),
    .addr     (addr),
    .wr_data  (pat),
    .rd_data  (cur_word),
    .flt_en   (flip_en),
    .flt_addr (flip_addr),
    .flt_mask (flip_mask)
  );

  shadow_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk     (clk),
    .wr_en   ((state == ST_FILL) || advance),
    .rd_en   (state == ST_READ),
    .addr    (addr),
    .wr_data ((state == ST_FILL) ? pat : cur_word),
    .rd_data (old_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr      <= '0;
      pat       <= '0;
      scan_idx  <= '0;
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_data  <= '0;
      rec_mask  <= '0;
      rec_count <= '0;
      rec_multi <= 1'b0;
      rec_stamp <= '0;
      scan_done <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      scan_done <= 1'b0;

      if (rec_valid && rec_ready) begin
        rec_valid <= 1'b0;
      end
      if (load) begin
        rec_valid <= 1'b1;
        rec_addr  <= addr;
        rec_data  <= cur_word;
        rec_mask  <= diff;
        rec_count <= ones_n;
        rec_multi <= (ones_n > CNT_W'(1));
        rec_stamp <= scan_idx;
      end

      if (tick && scanning) begin
        overrun <= 1'b1;
      end

      case (state)
        ST_IDLE: begin
          if (start) begin
            pat   <= DATA_W'(fill_word(pattern_sel, DATA_W));
            addr  <= '0;
            state <= ST_FILL;
          end
        end
        ST_FILL: begin
          addr <= addr + 1'b1;
          if (at_top) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            state <= ST_READ;
          end
        end
        ST_READ: begin
          state <= ST_CMP;
        end
        ST_CMP: begin
          if (advance) begin
            addr <= addr + 1'b1;
            if (at_top) begin
              scan_done <= 1'b1;
              scan_idx  <= scan_idx + 1'b1;
              state     <= ST_WAIT;
            end else begin
              state <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upset_monitor_chk.sv
`timescale 1ns/1ps
module upset_monitor_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int STAMP_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               rec_valid,
  input logic               rec_ready,
  input logic [ADDR_W-1:0]  rec_addr,
  input logic [DATA_W-1:0]  rec_data,
  input logic [DATA_W-1:0]  rec_mask,
  input logic               rec_multi,
  input logic [STAMP_W-1:0] rec_stamp,
  input logic               scan_done,
  input logic               overrun
);
  logic               have_last;
  logic [ADDR_W-1:0]  last_addr;
  logic [STAMP_W-1:0] last_stamp;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_last  <= 1'b0;
      last_addr  <= '0;
      last_stamp <= '0;
    end else if (rec_valid && rec_ready) begin
      have_last  <= 1'b1;
      last_addr  <= rec_addr;
      last_stamp <= rec_stamp;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  p_mask_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_mask != '0));

  p_addr_order_r5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && have_last && (rec_stamp == last_stamp)) |-> (rec_addr > last_addr));

  p_multi_flag_r6: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_multi == !$onehot0(rec_mask)));

  p_stamp_mono_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && have_last) |-> (rec_stamp >= last_stamp));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_addr) && $stable(rec_data)
                                   && $stable(rec_mask) && $stable(rec_stamp)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind upset_monitor upset_monitor_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .STAMP_W (STAMP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_addr  (rec_addr),
  .rec_data  (rec_data),
  .rec_mask  (rec_mask),
  .rec_multi (rec_multi),
  .rec_stamp (rec_stamp),
  .scan_done (scan_done),
  .overrun   (overrun)
);

// File: tb/tb_upset_monitor.sv
`timescale 1ns/1ps
module tb_upset_monitor;
  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int PW  = 16;
  localparam int TW  = 16;
  localparam int CW  = $clog2(DW + 1);
  localparam int N   = 1 << AW;
  localparam int PER = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    pattern_sel = 2'd0;
  logic [PW-1:0] scan_period = PW'(PER);
  logic          flip_en = 1'b0;
  logic [AW-1:0] flip_addr = '0;
  logic [DW-1:0] flip_mask = '0;
  logic          rec_valid;
  logic          rec_ready = 1'b1;
  logic [AW-1:0] rec_addr;
  logic [DW-1:0] rec_data;
  logic [DW-1:0] rec_mask;
  logic [CW-1:0] rec_count;
  logic          rec_multi;
  logic [TW-1:0] rec_stamp;
  logic          scan_done;
  logic          overrun;

  upset_monitor #(.ADDR_W(AW), .DATA_W(DW), .PERIOD_W(PW), .STAMP_W(TW)) dut (
    .clk(clk), .rst(rst), .start(start), .pattern_sel(pattern_sel),
    .scan_period(scan_period), .flip_en(flip_en), .flip_addr(flip_addr),
    .flip_mask(flip_mask), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_addr(rec_addr), .rec_data(rec_data), .rec_mask(rec_mask),
    .rec_count(rec_count), .rec_multi(rec_multi), .rec_stamp(rec_stamp),
    .scan_done(scan_done), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  int last_done_cyc = 0;
  int prev_done_cyc = 0;
  int got_n = 0;
  logic [AW-1:0] got_addr  [64];
  logic [DW-1:0] got_data  [64];
  logic [DW-1:0] got_mask  [64];
  logic [CW-1:0] got_count [64];
  logic          got_multi [64];
  logic [TW-1:0] got_stamp [64];

  logic [DW-1:0] exp_mem [N];
  logic [DW-1:0] pend    [N];

  // Monitor: samples at the falling edge, between driving instants.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (rec_valid && rec_ready && got_n < 64) begin
        got_addr[got_n]  <= rec_addr;
        got_data[got_n]  <= rec_data;
        got_mask[got_n]  <= rec_mask;
        got_count[got_n] <= rec_count;
        got_multi[got_n] <= rec_multi;
        got_stamp[got_n] <= rec_stamp;
        got_n <= got_n + 1;
      end
      if (scan_done) begin
        done_cnt      <= done_cnt + 1;
        prev_done_cyc <= last_done_cyc;
        last_done_cyc <= cyc;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int ones(input logic [DW-1:0] v);
    int n = 0;
    for (int i = 0; i < DW; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [DW-1:0] pat_of(input logic [1:0] s);
    case (s)
      2'd0:    return 16'h003F;
      2'd2:    return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic do_reset(input int per);
    rst = 1'b1;
    rec_ready = 1'b1;
    start = 1'b0;
    flip_en = 1'b0;
    scan_period = PW'(per);
    repeat (4) step();
    rst = 1'b0;
    done_cnt = 0;
    got_n = 0;
    step();
  endtask

  task automatic inject(input int a, input logic [DW-1:0] m, input bit track);
    flip_en = 1'b1;
    flip_addr = AW'(a);
    flip_mask = m;
    step();
    flip_en = 1'b0;
    if (track) begin
      exp_mem[a] = exp_mem[a] ^ m;
      pend[a]    = pend[a] ^ m;
    end
  endtask

  // R1 R2: start a fill, with faults thrown at it while it writes.
  task automatic start_run(input logic [1:0] s, input bit hit_fill);
    for (int a = 0; a < N; a++) begin
      exp_mem[a] = pat_of(s);
      pend[a] = '0;
    end
    pattern_sel = s;
    start = 1'b1;
    step();
    start = 1'b0;
    if (hit_fill) begin
      for (int i = 0; i < 12; i++) inject(i, 16'hFFFF, 1'b0);
    end
  endtask

  task automatic wait_done();
    int d = done_cnt;
    while (done_cnt == d) step();
  endtask

  // Wait for the scan to finish, then compare the collected records.
  task automatic collect_check(input int stamp);
    int k = 0;
    wait_done();
    repeat (3) step();
    for (int a = 0; a < N; a++) begin
      if (pend[a] != '0) begin
        if (k < got_n) begin
          chk(got_addr[k] == AW'(a), "R5 record address order", got_addr[k], a);
          chk(got_data[k] == exp_mem[a], "R4 R1 record data", got_data[k], exp_mem[a]);
          chk(got_mask[k] == pend[a], "R4 record mask", got_mask[k], pend[a]);
          chk(int'(got_count[k]) == ones(pend[a]), "R6 flipped bit count", got_count[k], ones(pend[a]));
          chk(got_multi[k] == (ones(pend[a]) > 1), "R6 multi flag", got_multi[k], ones(pend[a]) > 1);
          chk(int'(got_stamp[k]) == stamp, "R7 scan stamp", got_stamp[k], stamp);
        end
        k++;
        pend[a] = '0;
      end
    end
    chk(got_n == k, "R4 record count", got_n, k);
    got_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    do_reset(PER);
    // R10: reset state
    chk(rec_valid == 1'b0, "R10 rec_valid after reset", rec_valid, 0);
    chk(scan_done == 1'b0, "R10 scan_done after reset", scan_done, 0);
    chk(overrun == 1'b0, "R10 overrun after reset", overrun, 0);

    for (int s = 0; s < 4; s++) begin
      do_reset(PER);
      start_run(2'(s), 1'b1);
      // R2: fill-time faults are discarded, scan 0 is clean.
      collect_check(0);
      // R1: single-bit flips expose the fill pattern in rec_data.
      for (int a = 0; a < N; a++) inject(a, DW'(1) << ((a + s) % DW), 1'b1);
      collect_check(1);
      // R3: start spacing equals the programmed period.
      chk(last_done_cyc - prev_done_cyc == PER, "R3 scan spacing",
          last_done_cyc - prev_done_cyc, PER);
      // R6: two-bit flips on even words; R11: a double flip cancels.
      for (int a = 0; a < N; a += 2) inject(a, DW'(3) << (a % (DW - 1)), 1'b1);
      inject(3, 16'h0100, 1'b1);
      inject(3, 16'h0100, 1'b1);
      collect_check(2);
      // R4: earlier flips not reported again; one 3-bit upset.
      inject(N - 1, 16'h8011, 1'b1);
      collect_check(3);
      chk(overrun == 1'b0, "R9 no overrun at a long period", overrun, 0);
    end

    // R8 R9: stall the stream across a scan with several upsets.
    rec_ready = 1'b0;
    inject(2, 16'h0004, 1'b1);
    inject(5, 16'h0030, 1'b1);
    inject(9, 16'h8000, 1'b1);
    inject(14, 16'h0700, 1'b1);
    repeat (250) step();
    chk(rec_valid == 1'b1, "R8 record held while stalled", rec_valid, 1);
    chk(rec_addr == AW'(2), "R8 held record address", rec_addr, 2);
    chk(got_n == 0, "R8 nothing accepted while stalled", got_n, 0);
    chk(overrun == 1'b1, "R9 overrun after tick during stall", overrun, 1);
    rec_ready = 1'b1;
    collect_check(4);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    do_reset(PER);
    chk(overrun == 1'b0, "R10 overrun cleared by reset", overrun, 0);

    // R9: period equal to two cycles per word overruns.
    do_reset(2 * N);
    start_run(2'd1, 1'b0);
    repeat (3) wait_done();
    chk(overrun == 1'b1, "R9 overrun at period 2N", overrun, 1);
    chk(got_n == 0, "R4 no records without faults", got_n, 0);

    // R3 R9: one more cycle is enough.
    do_reset(2 * N + 1);
    start_run(2'd2, 1'b0);
    repeat (3) wait_done();
    chk(overrun == 1'b0, "R9 no overrun at period 2N+1", overrun, 0);
    chk(last_done_cyc - prev_done_cyc == 2 * N + 1, "R3 spacing at period 2N+1",
        last_done_cyc - prev_done_cyc, 2 * N + 1);

    summary();
    $finish;
  end
endmodule